// File: doc/BRIEF.md
# Decorated Store Read-Modify-Write Engine

This block sits between a bus master and a peripheral memory port. Most traffic passes straight through it. A write that carries command bits in its upper address is a "decorated" store. The engine turns each such write into an atomic read-modify-write on the slave side. It reads the target container, merges the master's write data into it, and writes the result back to the same location. While this runs, the master is held off.

Two merge operations are supported. The XOR store flips the bits of the container that are set in the operand. The bit-field insert replaces a field of the container with the matching bits of the operand. The field's lowest bit position and its width are both encoded in the address. The container can be a byte, a halfword or a word. The engine takes the operand and the read data from the byte lanes selected by the low address bits. The result is replicated across all lanes when it goes to the slave.

Top module: `dstore_rmw`

## Requirements
- R1: A write is a decorated store when `m_addr[30:29]` is 2'b10 and either `m_addr[28]` is 1 (bit-field insert) or `m_addr[28]` is 0 with `m_addr[27:26]` equal to 2'b11 (XOR). Both the read and the write-back of such a store go to address 0x4000_0000 plus the offset `m_addr[18:0]`. All higher address bits are ignored.
- R2: A decorated store takes three cycles, counted from the cycle in which it is presented:
  - In the first cycle the slave sees a read (`s_req`=1, `s_we`=0) and `m_ready` is 0.
  - In the second cycle `s_req` is 0 and `m_ready` is 0.
  - In the third cycle the slave sees a write to the same address and size, and `m_ready` is 1.
- R3: For an XOR store, the new container value equals the old container value XOR the operand. Bytes outside the container are left unchanged.
- R4: For a bit-field insert, the field starts at bit b = `m_addr[27:23]` and is w+1 bits wide, where w = `m_addr[22:19]`. The field bits take the matching bits of the operand, and every other container bit keeps its read value. Bit 19 is the low bit of w and is not part of the offset.
- R5: A bit-field insert with w = 0 changes at most the single bit b.
- R6: The size code `m_size` selects the container: 0 is a byte, 1 a halfword, 2 a word.
  - A byte container sits in lane `m_addr[1:0]`, and a halfword container in half `m_addr[1]`.
  - The operand is taken from that lane of `m_wdata`.
  - The write-back data is replicated across all lanes.
- R7: Field bits that fall above the container width are discarded. A word field is never wider than 16 bits.
- R8: Reads, and writes that are not decorated, pass to the slave in the same cycle. They keep their address, size and data unchanged and see no stall (`m_ready`=1). `m_rdata` always carries `s_rdata`.
- R9: After reset the engine is idle: `m_ready` is 1 and `s_req` is 0 while `m_req` is 0.
- R10: A write with `m_addr[30:29]` = 2'b10, `m_addr[28]` = 0 and `m_addr[27:26]` not equal to 2'b11 is forwarded as a plain write with its address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master transfer request, held until `m_ready` |
| m_we | input | 1 | Master write enable |
| m_addr | input | 32 | Master address, including the command bits |
| m_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Master write data, replicated across lanes for narrow accesses |
| m_ready | output | 1 | Transfer completes on a cycle with `m_req` and `m_ready` |
| m_rdata | output | 32 | Read data returned to the master |
| s_req | output | 1 | Slave request |
| s_we | output | 1 | Slave write enable |
| s_addr | output | 32 | Slave address |
| s_size | output | 2 | Slave access size |
| s_wdata | output | 32 | Slave write data |
| s_rdata | input | 32 | Slave read data, valid the cycle after a read request |

## Verification
Some properties are checked by assertions on every cycle:
- the three-phase shape of every decorated sequence, with the idle slave cycle and the stalled master in its middle;
- the write-back reusing the read's address;
- a zero-width-code field mask holding at most one bit;
- a byte container's mask never reaching past bit 7.

The merged values themselves can only be shown by the bench's scenarios. These compare memory contents against an independent bit-by-bit model over many container sizes, lanes, field positions and widths. The same applies to:
- the ignored high address bits;
- unsupported command codes being forwarded as plain writes;
- reads passing through with no stall.

// File: rtl/dstore_pkg.sv
package dstore_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2
   } seq_state_e;

   localparam logic [1:0] SIZE_BYTE = 2'd0;
   localparam logic [1:0] SIZE_HALF = 2'd1;
   localparam logic [1:0] SIZE_WORD = 2'd2;

   // bit offset of the container inside the 32-bit data bus
   function automatic logic [4:0] lane_shift(input logic [1:0] size, input logic [1:0] lane);
      case (size)
         SIZE_BYTE: return {lane, 3'b000};
         SIZE_HALF: return {lane[1], 4'b0000};
         default:   return 5'd0;
      endcase
   endfunction

   // ones over the container width, aligned at bit 0
   function automatic logic [31:0] size_mask(input logic [1:0] size);
      case (size)
         SIZE_BYTE: return 32'h0000_00FF;
         SIZE_HALF: return 32'h0000_FFFF;
         default:   return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/dstore_decode.sv
module dstore_decode #(
   parameter int                ADDR_W      = 32,
   parameter int                OFFSET_W    = 19,
   parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'h4000_0000,
   parameter logic [1:0]        XOR_CODE    = 2'b11
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output logic              dec_go,
   output logic              is_bfi,
   output logic [4:0]        bpos,
   output logic [3:0]        wm1,
   output logic [ADDR_W-1:0] xaddr
);
   // command field positions: fixed by the address encoding
   localparam int SEL_LO  = 29;
   localparam int BFI_BIT = 28;
   localparam int OPC_LO  = 26;
   localparam int BPOS_LO = 23;
   localparam int WM1_LO  = 19;

   if (ADDR_W < 31) begin : g_bad_addr
      $error("dstore_decode: ADDR_W must cover the command bits");
   end
   if (OFFSET_W > WM1_LO || OFFSET_W < 2) begin : g_bad_off
      $error("dstore_decode: OFFSET_W must lie below the width field");
   end

   logic periph, is_xor;
   logic unused_hi;

   always_comb begin
      periph = (addr[SEL_LO+1:SEL_LO] == 2'b10);
      is_bfi = addr[BFI_BIT];
      is_xor = !addr[BFI_BIT] && (addr[OPC_LO+1:OPC_LO] == XOR_CODE);
      bpos   = addr[BPOS_LO+4:BPOS_LO];
      wm1    = addr[WM1_LO+3:WM1_LO];
      dec_go = req && we && periph && (is_bfi || is_xor);
      xaddr  = PERIPH_BASE | ADDR_W'(addr[OFFSET_W-1:0]);
   end

   assign unused_hi = ^{addr[ADDR_W-1:SEL_LO+2], addr[WM1_LO-1:OFFSET_W]};

endmodule

// File: rtl/dstore_merge.sv
module dstore_merge
   import dstore_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MAX_FIELD = 16
) (
   input  logic [1:0]        size,
   input  logic [1:0]        lane,
   input  logic              is_bfi,
   input  logic [4:0]        bpos,
   input  logic [3:0]        wm1,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] out_word,
   output logic [DATA_W-1:0] fmask
);
   localparam int         LANES  = DATA_W / 8;
   localparam logic [5:0] MAX_FW = 6'(MAX_FIELD);

   if (MAX_FIELD < 1 || MAX_FIELD > 16) begin : g_bad_field
      $error("dstore_merge: MAX_FIELD must be 1..16");
   end

   logic [4:0]        sh;
   logic [5:0]        fw;
   logic [DATA_W-1:0] cmask, rd_c, op_c, ones, res_c;

   always_comb begin
      sh    = lane_shift(size, lane);
      cmask = size_mask(size);
      rd_c  = (rd_word >> sh) & cmask;
      op_c  = (wr_word >> sh) & cmask;
      fw    = {2'b00, wm1} + 6'd1;
      if (size == SIZE_WORD && fw > MAX_FW) fw = MAX_FW;
      ones  = (DATA_W'(1) << fw) - DATA_W'(1);
      fmask = (ones << bpos) & cmask;
      if (is_bfi) res_c = (rd_c & ~fmask) | (op_c & fmask);
      else        res_c = (rd_c ^ op_c) & cmask;
   end

   // replicate the container across every byte lane of the bus
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         case (size)
            SIZE_BYTE: out_word[8*i +: 8] = res_c[7:0];
            SIZE_HALF: out_word[8*i +: 8] = res_c[8*(i%2) +: 8];
            default:   out_word[8*i +: 8] = res_c[8*i +: 8];
         endcase
      end
   end

endmodule

// File: rtl/dstore_seq.sv
module dstore_seq
   import dstore_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic idle,
   output logic rd_phase,
   output logic wr_phase
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE:  if (start) state_d = SEQ_READ;
         SEQ_READ:  state_d = SEQ_WRITE;
         SEQ_WRITE: state_d = SEQ_IDLE;
         default:   state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign idle     = (state_q == SEQ_IDLE);
   assign rd_phase = (state_q == SEQ_READ);
   assign wr_phase = (state_q == SEQ_WRITE);

endmodule

// File: rtl/dstore_rmw.sv
module dstore_rmw
   import dstore_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                OFFSET_W    = 19,
   parameter int                MAX_FIELD   = 16,
   parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'h4000_0000,
   parameter logic [1:0]        XOR_CODE    = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_req,
   input  logic              m_we,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [1:0]        m_size,
   input  logic [DATA_W-1:0] m_wdata,
   output logic              m_ready,
   output logic [DATA_W-1:0] m_rdata,
   output logic              s_req,
   output logic              s_we,
   output logic [ADDR_W-1:0] s_addr,
   output logic [1:0]        s_size,
   output logic [DATA_W-1:0] s_wdata,
   input  logic [DATA_W-1:0] s_rdata
);
   if (DATA_W != 32) begin : g_bad_data
      $error("dstore_rmw: size codes assume a 32-bit data bus");
   end

   logic              dec_go, is_bfi, start, idle, rd_phase, wr_phase;
   logic [4:0]        bpos, cap_b;
   logic [3:0]        wm1, cap_w;
   logic [ADDR_W-1:0] xaddr, cap_addr;
   logic [1:0]        cap_size, cap_lane;
   logic              cap_bfi;
   logic [DATA_W-1:0] cap_wdata, merged, merged_q, fmask;

   dstore_decode #(
      .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W),
      .PERIPH_BASE(PERIPH_BASE), .XOR_CODE(XOR_CODE)
   ) u_decode (
      .req(m_req), .we(m_we), .addr(m_addr),
      .dec_go(dec_go), .is_bfi(is_bfi), .bpos(bpos), .wm1(wm1), .xaddr(xaddr)
   );

   dstore_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .idle(idle), .rd_phase(rd_phase), .wr_phase(wr_phase)
   );

   dstore_merge #(.DATA_W(DATA_W), .MAX_FIELD(MAX_FIELD)) u_merge (
      .size(cap_size), .lane(cap_lane), .is_bfi(cap_bfi), .bpos(cap_b), .wm1(cap_w),
      .rd_word(s_rdata), .wr_word(cap_wdata), .out_word(merged), .fmask(fmask)
   );

   assign start = idle && dec_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr  <= '0;
         cap_size  <= SIZE_WORD;
         cap_lane  <= '0;
         cap_bfi   <= 1'b0;
         cap_b     <= '0;
         cap_w     <= '0;
         cap_wdata <= '0;
         merged_q  <= '0;
      end else begin
         if (start) begin
            cap_addr  <= xaddr;
            cap_size  <= m_size;
            cap_lane  <= m_addr[1:0];
            cap_bfi   <= is_bfi;
            cap_b     <= bpos;
            cap_w     <= wm1;
            cap_wdata <= m_wdata;
         end
         if (rd_phase) merged_q <= merged;
      end
   end

   always_comb begin
      s_req   = m_req;
      s_we    = m_we;
      s_addr  = m_addr;
      s_size  = m_size;
      s_wdata = m_wdata;
      m_ready = 1'b1;
      if (wr_phase) begin
         s_req   = 1'b1;
         s_we    = 1'b1;
         s_addr  = cap_addr;
         s_size  = cap_size;
         s_wdata = merged_q;
      end else if (rd_phase) begin
         s_req   = 1'b0;
         s_we    = 1'b0;
         s_addr  = cap_addr;
         s_size  = cap_size;
         m_ready = 1'b0;
      end else if (start) begin
         s_req   = 1'b1;
         s_we    = 1'b0;
         s_addr  = xaddr;
         m_ready = 1'b0;
      end
   end

   assign m_rdata = s_rdata;

   // R2: middle cycle leaves the slave idle and the master stalled
   assert_seq_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!s_req && !m_ready));

   // R2: third cycle writes back and releases the master
   assert_seq_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ##2 (s_req && s_we && m_ready));

   // R1: write-back goes to the address and size that were read
   assert_same_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ##2 (s_addr == $past(s_addr, 2) && s_size == $past(s_size, 2)));

   // R5: a zero width code yields at most one field bit
   assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_phase && cap_bfi && cap_w == 4'd0) |-> ($countones(fmask) <= 1));

   // R7: a byte container never receives field bits above bit 7
   assert_field_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_phase && cap_size == SIZE_BYTE) |-> (fmask[DATA_W-1:8] == '0));

endmodule

// File: tb/dstore_rmw_bench.sv
module dstore_rmw_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_req = 1'b0, m_we = 1'b0;
   logic [31:0] m_addr = '0, m_wdata = '0;
   logic [1:0]  m_size = 2'd2;
   logic        m_ready, s_req, s_we;
   logic [31:0] m_rdata, s_addr, s_wdata;
   logic [1:0]  s_size;
   logic [31:0] s_rdata = '0;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 0;

   always #5ns clk = ~clk;

   dstore_rmw u_dstore_rmw (
      .clk(clk), .rst_n(rst_n),
      .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rdata(m_rdata),
      .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_size(s_size), .s_wdata(s_wdata),
      .s_rdata(s_rdata)
   );

   // slave memory model: one-cycle read latency, lane-masked writes
   logic [31:0] mem [16];
   logic [31:0] last_waddr = '0;
   logic        pl_en = 1'b0;
   logic [3:0]  pl_idx = '0;
   logic [31:0] pl_val = '0;

   always @(posedge clk) begin
      if (pl_en) mem[pl_idx] <= pl_val;
      if (s_req && s_we) begin
         last_waddr <= s_addr;
         case (s_size)
            2'd0:    mem[s_addr[5:2]][8*s_addr[1:0] +: 8] <= s_wdata[8*s_addr[1:0] +: 8];
            2'd1:    mem[s_addr[5:2]][16*s_addr[1] +: 16] <= s_wdata[16*s_addr[1] +: 16];
            default: mem[s_addr[5:2]] <= s_wdata;
         endcase
      end
      if (s_req && !s_we) s_rdata <= mem[s_addr[5:2]];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic preload(input logic [3:0] idx, input logic [31:0] val);
      @(negedge clk);
      pl_en = 1'b1; pl_idx = idx; pl_val = val;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic do_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                           output int stalls, output logic [31:0] waddr);
      @(negedge clk);
      m_req = 1'b1; m_we = 1'b1; m_addr = a; m_size = sz; m_wdata = d;
      stalls = 0;
      #1ns;
      while (!m_ready) begin
         stalls++;
         @(negedge clk);
         #1ns;
      end
      @(posedge clk);
      #1ns;
      waddr = last_waddr;
      m_req = 1'b0; m_we = 1'b0;
   endtask

   // independent bit-by-bit model of the container update
   function automatic logic [31:0] ref_word(input logic [31:0] init, input logic [31:0] a,
                                            input logic [1:0] sz, input logic [31:0] d);
      int sh, cw, b, w;
      logic [31:0] res;
      sh  = (sz == 2'd0) ? 8 * int'(a[1:0]) : (sz == 2'd1) ? 16 * int'(a[1]) : 0;
      cw  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      b   = int'(a[27:23]);
      w   = int'(a[22:19]);
      res = init;
      for (int i = 0; i < cw; i++) begin
         if (a[28]) begin
            if (i >= b && i <= b + w) res[sh+i] = d[sh+i];
         end else begin
            res[sh+i] = init[sh+i] ^ d[sh+i];
         end
      end
      return res;
   endfunction

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  size;
      logic [31:0] wdata;
      logic [31:0] init;
      logic [31:0] result;
      logic [1:0]  stalls;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'h4C00_0010, 2'd2, 32'h0F0F_0F0F, 32'hFFFF_0000, 32'hF0F0_0F0F, 2'd2}, // R3 word xor
      '{32'h5218_0014, 2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FF0F, 2'd2}, // R4 b=4 w=3
      '{32'h5080_001A, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0002_0000, 2'd2}, // R5 R6 lane 2
      '{32'h5318_001C, 2'd0, 32'hFFFF_FFFF, 32'h1234_5600, 32'h1234_56C0, 2'd2}, // R7 clip
      '{32'h4C00_0022, 2'd1, 32'h0F0F_0F0F, 32'hAAAA_5555, 32'hA5A5_5555, 2'd2}, // R6 upper half
      '{32'h5878_0024, 2'd2, 32'hABCD_1234, 32'h0000_FFFF, 32'hABCD_FFFF, 2'd2}, // R7 16-bit field
      '{32'hD218_0030, 2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FF0F, 2'd2}, // R1 bit31 ignored
      '{32'h4400_0028, 2'd2, 32'h55AA_55AA, 32'h0000_0000, 32'h55AA_55AA, 2'd0}, // R10 other code
      '{32'h2000_002C, 2'd2, 32'h0102_0304, 32'hFFFF_FFFF, 32'h0102_0304, 2'd0}  // R8 plain write
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      int          st;
      logic [31:0] wa, exp_wa;
      for (int i = 0; i < 16; i++) mem[i] = '0;

      // R9: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready after reset", {31'd0, m_ready}, 32'd1);
      chk("R9 no slave request", {31'd0, s_req}, 32'd0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         preload(VECS[v].addr[5:2], VECS[v].init);
         do_write(VECS[v].addr, VECS[v].size, VECS[v].wdata, st, wa);
         exp_wa = (VECS[v].stalls == 2'd2) ? (32'h4000_0000 | {13'd0, VECS[v].addr[18:0]})
                                           : VECS[v].addr;
         chk($sformatf("R3 R4 R6 R7 R10 memory vec%0d", v), mem[VECS[v].addr[5:2]], VECS[v].result);
         chk($sformatf("R2 R8 stall cycles vec%0d", v), st, 32'(VECS[v].stalls));
         chk($sformatf("R1 R8 write address vec%0d", v), wa, exp_wa);
      end

      // R8: a read at a decorated-looking address passes through, no stall
      @(negedge clk);
      m_req = 1'b1; m_we = 1'b0; m_addr = 32'h5218_0014; m_size = 2'd2;
      #1ns;
      chk("R8 read not stalled", {31'd0, m_ready}, 32'd1);
      chk("R8 read address unchanged", s_addr, 32'h5218_0014);
      @(posedge clk);
      #1ns;
      m_req = 1'b0;
      @(negedge clk);
      chk("R8 read data", m_rdata, 32'hFFFF_FF0F);

      // random decorated stores against the reference model
      for (int r = 0; r < 40; r++) begin
         logic [31:0] a, d, init, exp;
         logic [1:0]  sz;
         logic [1:0]  ln;
         logic [3:0]  idx;
         sz  = 2'($urandom_range(0, 2));
         ln  = (sz == 2'd0) ? 2'($urandom) : (sz == 2'd1) ? {1'($urandom), 1'b0} : 2'b00;
         idx = 4'(12 + $urandom_range(0, 3));
         d   = $urandom;
         if (sz == 2'd0) d = {4{d[7:0]}};
         else if (sz == 2'd1) d = {2{d[15:0]}};
         init = $urandom;
         if ($urandom_range(0, 1) == 1)
            a = 32'h5000_0000 | (32'($urandom_range(0, 31)) << 23) | (32'($urandom_range(0, 15)) << 19);
         else
            a = 32'h4C00_0000 | (32'($urandom_range(0, 127)) << 19);
         a[31]  = 1'($urandom);
         a[5:0] = {idx, ln};
         exp = ref_word(init, a, sz, d);
         preload(idx, init);
         do_write(a, sz, d, st, wa);
         chk($sformatf("R3 R4 R6 random %0d", r), mem[idx], exp);
         chk($sformatf("R2 random stalls %0d", r), st, 32'd2);
         chk($sformatf("R1 random address %0d", r), wa, 32'h4000_0000 | {13'd0, a[18:0]});
      end

      // R5: single bit insert of a zero into an all-ones word at bit 31
      preload(4'd3, 32'hFFFF_FFFF);
      do_write(32'h5F80_000C, 2'd2, 32'h0000_0000, st, wa);
      chk("R5 single bit cleared", mem[3], 32'h7FFF_FFFF);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule